// File: doc/BRIEF.md
# ADC Register Configuration Sequencer

This block brings a two-channel differential SAR converter out of power-up into a working configuration. It does this over a 4-wire SPI link that it drives itself. One pulse on `start` makes it send a fixed list of register writes. Each write is a 24-bit frame: an 8-bit register address followed by a 16-bit value. The list runs in this order:

- the reset pulse;
- a two-frame key that opens the register map;
- the internal reference enable, with its settling pause;
- a detour through the second register bank;
- the output format and lane selection;
- a closing key that locks the map again.

Timed pauses are counted in system clocks per microsecond, so the 1 ms and 25 ms delays follow the clock frequency.

The controller is a five-state machine:
- `ST_IDLE` waits for `start`.
- `ST_SEND` pulses the frame shifter for one cycle.
- `ST_XFER` waits for the shifted frame and its trailing chip-select gap.
- `ST_PAUSE` waits for the pause timer.
- `ST_DONE` holds the finished state.

The transitions are:
- idle→send on `start`.
- send→xfer always.
- xfer→pause when the finished step carries a pause.
- xfer→send when it has no pause and is not the last step.
- xfer→done when it has no pause and is the last step.
- pause→send when the timer runs out.
- pause→done when the timer runs out on the last step.

The shifter has its own states, `TX_IDLE`, `TX_SHIFT` and `TX_GAP`. The reset write happens only once, so `ST_DONE` is left only through `rst_n`.

Top module: `cfgseq_adc_init`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cs_n`=1, `sclk`=0, `busy`=0 and `done`=0 until `start` is seen.
- R2: Each frame drops `cs_n` and gives exactly 24 rising `sclk` edges while `cs_n` is low. The MSB goes first, with bits 23:16 the address and bits 15:0 the value. `sclk` idles low, and `mosi` changes only while `sclk` is low (the slave samples on the rising edge).
- R3: The high and low phases of `sclk` each last `SCLK_HALF` system clocks, and the first rising edge comes `SCLK_HALF` clocks after `cs_n` falls.
- R4: With the default list, the frames are, in order (address:value):
  - 01:0002, 01:0000
  - FE:B38F, FE:ABCD
  - 02:0002
  - 0C:1200, 0C:0200
  - 03:000B, 02:0008
  - 22:0080, 02:0002
  - 0D:0100, 09:0460
  - FE:1234
- R5: Between the first frame (reset asserted) and the second, `cs_n` stays high for at least `CLK_PER_US*RESET_WAIT_US` clocks.
- R6: Between the 0C:1200 frame and the 0C:0200 frame, `cs_n` stays high for at least `CLK_PER_US*REF_WAIT_US` clocks.
- R7: Between any two frames, `cs_n` stays high for at least `GAP_CLKS` clocks.
- R8: `busy` is high from the cycle after an accepted `start` until the lock frame and its trailing gap are complete. `done` rises in the cycle `busy` falls. `cs_n` is high whenever `busy` is low.
- R9: A `start` pulse while `busy` is high is ignored: the run is not restarted, and exactly 14 frames are sent.
- R10: `done` stays high. A `start` after completion sends no frame, so the reset write is never repeated until `rst_n` is pulsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to run the sequence |
| sclk | output | 1 | SPI serial clock, idle low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI serial data to the converter |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished and registers locked |

## Verification
The bench builds the block with the following parameters:
- `CLK_PER_US=2`, `RESET_WAIT_US=3` and `REF_WAIT_US=5`, so the reset pause is 6 clocks and the reference pause is 10 clocks.
- `SCLK_HALF=2` and `GAP_CLKS=3`.

These values make the whole 14-frame run take about 1500 cycles. This lets one run cover the exact frame order, both timed pauses as measured chip-select gaps, the half-period count of every serial-clock phase, and a restart attempt both mid-run and after lock. Since `SCLK_HALF` is above 1, the half-period counter actually wraps. The short pauses still stand clearly longer than the plain inter-frame gap, so each pause is told apart from the ordinary gap by its length.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    localparam int FRAME_W   = 24;
    localparam int DEF_STEPS = 14;

    typedef enum logic [1:0] {
        WAIT_NONE  = 2'd0,
        WAIT_SHORT = 2'd1,
        WAIT_LONG  = 2'd2
    } wait_e;

    // Step list, first step in the most significant slice: {addr[7:0], value[15:0]}
    localparam logic [DEF_STEPS*FRAME_W-1:0] DEF_LIST = {
        24'h01_0002,  // converter reset on
        24'h01_0000,  // converter reset off
        24'hFE_B38F,  // key part one
        24'hFE_ABCD,  // key part two
        24'h02_0002,  // bank 1
        24'h0C_1200,  // reference start
        24'h0C_0200,  // reference run
        24'h03_000B,  // bank 2 open, part one
        24'h02_0008,  // bank 2 open, part two
        24'h22_0080,  // second init step
        24'h02_0002,  // back to bank 1
        24'h0D_0100,  // output format
        24'h09_0460,  // single lane, low latency
        24'hFE_1234   // lock
    };

    // Pause after each step, same ordering, 2 bits per step
    localparam logic [2*DEF_STEPS-1:0] DEF_WAIT =
        28'b01_00_00_00_00_10_00_00_00_00_00_00_00_00;

endpackage

// File: rtl/cfgseq_spi_tx.sv
module cfgseq_spi_tx #(
    parameter int FRAME_W   = 24,
    parameter int SCLK_HALF = 2,
    parameter int GAP_CLKS  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] frame,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    output logic               frame_done
);

    localparam int HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int GW = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;
    localparam int BW = $clog2(FRAME_W);

    typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_state_e;

    tx_state_e          st_q, st_d;
    logic [HW-1:0]      half_q;
    logic [GW-1:0]      gap_q;
    logic [BW-1:0]      bit_q;
    logic [FRAME_W-1:0] sh_q;
    logic               sclk_q, cs_q;
    logic               half_end, last_bit, gap_end;

    assign half_end = (half_q == HW'(SCLK_HALF - 1));
    assign last_bit = (bit_q == BW'(FRAME_W - 1));
    assign gap_end  = (gap_q == GW'(GAP_CLKS - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:  if (go) st_d = TX_SHIFT;
            TX_SHIFT: if (half_end && sclk_q && last_bit) st_d = TX_GAP;
            TX_GAP:   if (gap_end) st_d = TX_IDLE;
            default:  st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= '0;
            gap_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            unique case (st_q)
                TX_IDLE: begin
                    if (go) begin
                        sh_q   <= frame;
                        bit_q  <= '0;
                        half_q <= '0;
                        sclk_q <= 1'b0;
                        cs_q   <= 1'b0;
                    end
                end
                TX_SHIFT: begin
                    if (half_end) begin
                        half_q <= '0;
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (last_bit) begin
                                cs_q  <= 1'b1;
                                gap_q <= '0;
                            end else begin
                                sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end else begin
                        half_q <= half_q + 1'b1;
                    end
                end
                TX_GAP:  gap_q <= gap_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign sclk       = sclk_q;
    assign cs_n       = cs_q;
    assign mosi       = sh_q[FRAME_W-1];
    assign frame_done = (st_q == TX_GAP) && gap_end;

    // R2: a rising serial clock edge happens only inside a frame
    p_rise_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !cs_n);

    // R2: data holds while the serial clock stays high
    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/cfgseq_wait_timer.sv
module cfgseq_wait_timer #(
    parameter int SHORT_CLKS = 100000,
    parameter int LONG_CLKS  = 2500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] sel,
    output logic       running
);

    localparam int MAXC = (LONG_CLKS > SHORT_CLKS) ? LONG_CLKS : SHORT_CLKS;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (sel == cfgseq_pkg::WAIT_LONG) ? CW'(LONG_CLKS) : CW'(SHORT_CLKS);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign running = (cnt_q != '0);

    // R5: a running pause loses exactly one clock per cycle
    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !load) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/cfgseq_adc_init.sv
module cfgseq_adc_init #(
    parameter int N_STEPS = cfgseq_pkg::DEF_STEPS,
    parameter logic [N_STEPS*cfgseq_pkg::FRAME_W-1:0] STEP_LIST = cfgseq_pkg::DEF_LIST,
    parameter logic [2*N_STEPS-1:0] WAIT_SEL = cfgseq_pkg::DEF_WAIT,
    parameter int CLK_PER_US    = 100,
    parameter int RESET_WAIT_US = 1000,
    parameter int REF_WAIT_US   = 25000,
    parameter int SCLK_HALF     = 4,
    parameter int GAP_CLKS      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic sclk,
    output logic cs_n,
    output logic mosi,
    output logic busy,
    output logic done
);

    localparam int FW = cfgseq_pkg::FRAME_W;
    localparam int IW = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;

    typedef enum logic [2:0] {ST_IDLE, ST_SEND, ST_XFER, ST_PAUSE, ST_DONE} seq_state_e;

    seq_state_e    st_q, st_d;
    logic [IW-1:0] idx_q;
    logic [FW-1:0] cur_frame;
    logic [1:0]    cur_wait;
    logic          last_step, tx_go, tx_done, tmr_load, tmr_run, step_adv;

    assign cur_frame = STEP_LIST[(N_STEPS - 1 - int'(idx_q))*FW +: FW];
    assign cur_wait  = WAIT_SEL[(N_STEPS - 1 - int'(idx_q))*2 +: 2];
    assign last_step = (idx_q == IW'(N_STEPS - 1));
    assign tmr_load  = (st_q == ST_XFER) && tx_done && (cur_wait != 2'b00);
    assign step_adv  = !last_step &&
                       (((st_q == ST_XFER) && tx_done && (cur_wait == 2'b00)) ||
                        ((st_q == ST_PAUSE) && !tmr_run));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_SEND;
            ST_SEND:  st_d = ST_XFER;
            ST_XFER:  if (tx_done) begin
                          if (cur_wait != 2'b00) st_d = ST_PAUSE;
                          else if (last_step)    st_d = ST_DONE;
                          else                   st_d = ST_SEND;
                      end
            ST_PAUSE: if (!tmr_run) st_d = last_step ? ST_DONE : ST_SEND;
            ST_DONE:  st_d = ST_DONE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        idx_q <= '0;
        else if (step_adv) idx_q <= idx_q + 1'b1;
    end

    always_comb begin
        tx_go = (st_q == ST_SEND);
        busy  = (st_q == ST_SEND) || (st_q == ST_XFER) || (st_q == ST_PAUSE);
        done  = (st_q == ST_DONE);
    end

    cfgseq_spi_tx #(
        .FRAME_W  (FW),
        .SCLK_HALF(SCLK_HALF),
        .GAP_CLKS (GAP_CLKS)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (tx_go),
        .frame     (cur_frame),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .frame_done(tx_done)
    );

    cfgseq_wait_timer #(
        .SHORT_CLKS(CLK_PER_US * RESET_WAIT_US),
        .LONG_CLKS (CLK_PER_US * REF_WAIT_US)
    ) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .sel    (cur_wait),
        .running(tmr_run)
    );

    // R8: no chip select activity outside a run
    p_quiet_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    // R10: completion is held and never returns to busy
    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !busy));

    // R9: a run begins only from a start request
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R7: a new frame is launched only while chip select is released
    p_go_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> cs_n);

endmodule

// File: tb/tb_cfgseq_adc_init.sv
module tb_cfgseq_adc_init;

    localparam int CPU = 2, RWU = 3, FWU = 5, HALF = 2, GAP = 3, NF = 14;
    localparam int LIMIT = 6000;

    localparam logic [23:0] EXP [NF] = '{
        24'h010002, 24'h010000, 24'hFEB38F, 24'hFEABCD, 24'h020002,
        24'h0C1200, 24'h0C0200, 24'h03000B, 24'h020008, 24'h220080,
        24'h020002, 24'h0D0100, 24'h090460, 24'hFE1234};
    localparam int MINGAP [NF] = '{0, CPU*RWU, GAP, GAP, GAP, GAP, CPU*FWU,
                                   GAP, GAP, GAP, GAP, GAP, GAP, GAP};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic sclk, cs_n, mosi, busy, done;

    always #5 clk = ~clk;

    cfgseq_adc_init #(
        .CLK_PER_US(CPU), .RESET_WAIT_US(RWU), .REF_WAIT_US(FWU),
        .SCLK_HALF(HALF), .GAP_CLKS(GAP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk),
        .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done)
    );

    int checks = 0, errors = 0;
    int nf = 0, bits = 0, gapcnt = 0, run = 0;
    int bit_errs = 0, half_errs = 0, mosi_errs = 0;
    logic [23:0] shreg = '0;
    logic [23:0] got [32];
    int gapv [32];
    logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // frame monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n && sclk && !p_sclk) begin
                shreg = {shreg[22:0], mosi};
                bits++;
            end
            if (!cs_n && p_cs) begin
                bits = 0;
                if (nf > 0 && nf < 32) gapv[nf] = gapcnt;
            end
            if (cs_n && !p_cs) begin
                if (bits != 24) bit_errs++;
                if (nf < 32) got[nf] = shreg;
                nf++;
                gapcnt = 1;
            end else if (cs_n) begin
                gapcnt++;
            end
            if (sclk != p_sclk || (!cs_n && p_cs)) begin
                if (sclk != p_sclk && run != HALF) half_errs++;
                run = 1;
            end else begin
                run++;
            end
            if (!cs_n && mosi != p_mosi && !p_cs && sclk) mosi_errs++;
            if (cs_n && sclk) bit_errs++;
        end
        p_sclk = sclk;
        p_cs   = cs_n;
        p_mosi = mosi;
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    initial begin
        bit ok;
        int w;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cs_n == 1 && sclk == 0 && busy == 0 && done == 0, "R1", "in reset",
            {cs_n, sclk, busy, done}, 4'b1000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(cs_n == 1 && sclk == 0 && busy == 0 && done == 0, "R1", "idle after reset",
            {cs_n, sclk, busy, done}, 4'b1000);

        // R8: busy rises in the cycle after start
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1 && done == 0, "R8", "busy after start", {busy, done}, 2'b10);

        // R9: second start mid-run
        w = 0;
        while (nf < 3 && w < LIMIT) begin @(negedge clk); w++; end
        pulse_start();

        // wait for completion, watchdog bound
        w = 0;
        while (!done && w < LIMIT) begin
            chk(busy == 1, "R8", "busy held during run", busy, 1);
            @(negedge clk);
            w++;
        end
        chk(w < LIMIT, "R8", "watchdog expired before done", w, LIMIT);
        chk(busy == 0 && cs_n == 1, "R8", "busy low and cs high at done",
            {busy, cs_n}, 2'b01);
        chk(nf == NF, "R9", "frame count with mid-run start", nf, NF);

        // frame table walk
        for (int i = 0; i < NF; i++) begin
            chk(got[i] == EXP[i], "R4", $sformatf("frame %0d", i), got[i], EXP[i]);
            if (i == 1)
                chk(gapv[i] >= MINGAP[i], "R5", "reset pause", gapv[i], MINGAP[i]);
            else if (i == 6)
                chk(gapv[i] >= MINGAP[i], "R6", "reference pause", gapv[i], MINGAP[i]);
            else if (i > 0)
                chk(gapv[i] >= MINGAP[i], "R7", $sformatf("gap before %0d", i),
                    gapv[i], MINGAP[i]);
        end
        ok = (got[0] == 24'h010002) && (got[2] == 24'hFEB38F);
        chk(ok, "R5", "reset precedes key", got[0], 24'h010002);
        chk(bit_errs == 0, "R2", "24 rising edges per frame, sclk idle low", bit_errs, 0);
        chk(mosi_errs == 0, "R2", "mosi stable while sclk high", mosi_errs, 0);
        chk(half_errs == 0, "R3", "sclk half period length", half_errs, 0);

        // R10: start after lock is ignored
        pulse_start();
        repeat (300) @(negedge clk);
        chk(nf == NF, "R10", "no frame after done", nf, NF);
        chk(done == 1 && busy == 0 && cs_n == 1, "R10", "done held",
            {done, busy, cs_n}, 3'b101);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule